// File: doc/BRIEF.md
# Clock-Stretching I2C Target

This block is an I2C target with a fixed 7-bit address. It samples the open-drain clock and data lines through two-flop synchronizers and finds START and STOP conditions. It shifts in the address byte and acknowledges it if the address matches. After that it either receives data bytes from the controller or sends data bytes to it, as the R/W bit selects. A transfer may carry any number of bytes. It ends at a STOP or at a repeated START.

On the local side there are two valid/ready byte channels. Received bytes come out on one channel and wait until the local logic accepts them. Bytes to transmit are taken from the other channel. The local side may be slow in either direction. If it is, the target holds the clock line low in the low phase between bytes until the byte has been consumed or supplied. This stalls the controller without losing data. The target only ever pulls a line low and never drives it high. Each line is driven through a "drive low" output that the wrapper connects to an open-drain pad.

Top module: `i2c_stretch_target`

## Requirements
- R1: After a START, the target shifts in 8 bits on the SCL rising edges, MSB first. The first seven bits are the address and the eighth is R/W, where 1 means the controller reads. If the address equals `OWN_ADDR`, the target pulls SDA low for the whole 9th clock.
- R2: If the address does not match, the target drives neither line and does not acknowledge. It presents no received byte and takes no transmit byte until the next START or STOP.
- R3: In a write, each group of 8 data bits is assembled MSB first and appears on `rx_data` with `rx_valid` high, starting just after the 8th rising edge. `rx_valid` and `rx_data` stay unchanged until a cycle in which `rx_ready` is high.
- R4: In a write, the target pulls SDA low on the 9th clock of every data byte.
- R5: In a write, if the previous byte has not been accepted when the low phase before the 9th clock begins, the target holds SCL low. It releases SCL after the byte has been accepted. If the byte is accepted earlier, there is no stretch.
- R6: In a read, the target takes one byte through the `tx_valid`/`tx_ready` handshake for each data byte. It shifts the byte out MSB first and changes its SDA drive only while SCL is low.
- R7: In a read, the target holds SCL low from the low phase after each acknowledged 9th clock until a transmit byte is offered. It then releases SCL.
- R8: In a read, a NACK (SDA high on the 9th rising edge) ends transmission. The target releases SDA and takes no further transmit byte until the next START.
- R9: A START seen at any point, including mid-byte, clears the bit count and restarts address reception. A STOP returns the target to idle.
- R10: The target pulls SCL low only in the low phase, as seen through the synchronizer. It never pulls SCL low while the synchronized SCL is high.
- R11: After reset, both line drives are released, `rx_valid` is low and `tx_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_drive_low | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_drive_low | output | 1 | 1 pulls SDA low (ACK or data 0) |
| rx_data | output | 8 | Received data byte |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Local side accepts the received byte |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmit byte taken this cycle |

## Verification
Several properties are checked on every clock:
- SCL is never pulled low while the synchronized SCL is high.
- The SDA drive never changes during a high phase that has no START or STOP.
- A pending received byte stays stable until it is accepted.
- A transmit byte is only taken while SCL is held.
- The target stays quiet once it has been told to ignore the bus.

Other behaviour only the bench scenarios can show:
- Address matching.
- The bit order of data in both directions.
- Whether a stretch happens, depending on how late the local side responds.
- Recovery from a repeated START that arrives mid-byte.
- No byte is taken after a NACK.

// File: rtl/i2c_stretch_target.sv
module i2c_stretch_target #(
  parameter logic [6:0] OWN_ADDR = 7'h3A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_drive_low,
  output logic       sda_drive_low,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  input  logic       rx_ready,
  input  logic [7:0] tx_data,
  input  logic       tx_valid,
  output logic       tx_ready
);

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_ADDR_END, S_ADDR_ACK,
    S_RX, S_RX_END, S_RX_ACK,
    S_TX_LOAD, S_TX, S_TX_END, S_TX_MACK, S_TX_NEXT,
    S_IGNORE
  } state_t;

  state_t      state;
  logic [2:0]  scl_sh, sda_sh;
  logic [2:0]  cnt;
  logic [7:0]  shreg;
  logic        rw, sda_low;

  wire scl_s     = scl_sh[1];
  wire scl_q     = scl_sh[2];
  wire sda_s     = sda_sh[1];
  wire scl_rise  = scl_s & ~scl_q;
  wire scl_fall  = ~scl_s & scl_q;
  wire start_det = scl_s & scl_q & sda_sh[2] & ~sda_s;
  wire stop_det  = scl_s & scl_q & ~sda_sh[2] & sda_s;

  assign sda_drive_low = sda_low;
  assign scl_drive_low = (state == S_TX_LOAD) | ((state == S_RX_ACK) & rx_valid);
  assign tx_ready      = (state == S_TX_LOAD) & tx_valid & ~start_det & ~stop_det;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= 3'b111;
      sda_sh <= 3'b111;
    end else begin
      scl_sh <= {scl_sh[1:0], scl_i};
      sda_sh <= {sda_sh[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      shreg    <= '0;
      rw       <= 1'b0;
      sda_low  <= 1'b0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      if (start_det) begin
        state   <= S_ADDR;
        cnt     <= '0;
        sda_low <= 1'b0;
      end else if (stop_det) begin
        state   <= S_IDLE;
        sda_low <= 1'b0;
      end else begin
        case (state)
          S_ADDR: if (scl_rise) begin
            shreg <= {shreg[6:0], sda_s};
            cnt   <= cnt + 3'd1;
            if (cnt == 3'd7) state <= S_ADDR_END;
          end
          S_ADDR_END: if (scl_fall) begin
            if (shreg[7:1] == OWN_ADDR) begin
              sda_low <= 1'b1;
              rw      <= shreg[0];
              state   <= S_ADDR_ACK;
            end else begin
              state <= S_IGNORE;
            end
          end
          S_ADDR_ACK: if (scl_fall) begin
            sda_low <= 1'b0;
            cnt     <= '0;
            state   <= rw ? S_TX_LOAD : S_RX;
          end
          S_RX: if (scl_rise) begin
            shreg <= {shreg[6:0], sda_s};
            cnt   <= cnt + 3'd1;
            if (cnt == 3'd7) begin
              rx_data  <= {shreg[6:0], sda_s};
              rx_valid <= 1'b1;
              state    <= S_RX_END;
            end
          end
          S_RX_END: if (scl_fall) begin
            sda_low <= 1'b1;
            state   <= S_RX_ACK;
          end
          S_RX_ACK: if (scl_fall) begin
            sda_low <= 1'b0;
            cnt     <= '0;
            state   <= S_RX;
          end
          S_TX_LOAD: if (tx_valid) begin
            shreg   <= tx_data;
            sda_low <= ~tx_data[7];
            cnt     <= '0;
            state   <= S_TX;
          end
          S_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 3'd1;
              if (cnt == 3'd7) state <= S_TX_END;
            end
            if (scl_fall) begin
              shreg   <= {shreg[6:0], 1'b0};
              sda_low <= ~shreg[6];
            end
          end
          S_TX_END: if (scl_fall) begin
            sda_low <= 1'b0;
            state   <= S_TX_MACK;
          end
          S_TX_MACK: if (scl_rise) state <= sda_s ? S_IGNORE : S_TX_NEXT;
          S_TX_NEXT: if (scl_fall) state <= S_TX_LOAD;
          default: ;
        endcase
      end
    end
  end

  p_scl_low_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    scl_drive_low |-> !scl_s)
    else $error("SCL pulled low while synchronized SCL high");

  p_sda_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && scl_q && !start_det && !stop_det) |=> $stable(sda_drive_low))
    else $error("SDA drive changed during SCL high phase");

  p_rx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)))
    else $error("pending received byte dropped or changed");

  p_take_while_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> scl_drive_low)
    else $error("transmit byte taken without holding SCL");

  p_ignore_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IGNORE) |-> (!sda_drive_low && !scl_drive_low && !tx_ready))
    else $error("bus driven while ignoring");

endmodule

// File: tb/i2c_stretch_target_tb.sv
`timescale 1ns/1ps
module i2c_stretch_target_tb;
  localparam logic [6:0] TGT = 7'h3A;
  localparam int Q = 10;
  localparam int H = 20;
  localparam int RX_SLOW = 100;
  localparam int TX_SLOW = 700;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic dut_scl_low, dut_sda_low;
  logic [7:0] rx_data, tx_data = 8'h00;
  logic rx_valid, tx_ready;
  logic rx_ready = 1'b0, tx_valid = 1'b0;
  wire scl_line = ~(m_scl_low | dut_scl_low);
  wire sda_line = ~(m_sda_low | dut_sda_low);

  int checks = 0, fails = 0;
  logic [7:0] wb[0:15], got[0:15], tbytes[0:15];
  int rdly[0:15], tdly[0:15];
  int got_n = 0, rcnt = 0;
  int tx_idx = 0, tx_total = 0, tcnt = 0;
  logic tx_armed = 1'b0, hs = 1'b0;
  int sda_viol = 0, scl_viol = 0;
  logic prev_scl = 1'b1, prev_sda_drv = 1'b0, prev_scl_drv = 1'b0;

  always #2 clk = ~clk;

  i2c_stretch_target #(.OWN_ADDR(TGT)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_drive_low(dut_scl_low), .sda_drive_low(dut_sda_low),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready));

  always @(negedge clk) begin
    if (!rst_n) begin rx_ready = 1'b0; rcnt = 0; end
    else if (rx_ready) rx_ready = 1'b0;
    else if (rx_valid && got_n < 16) begin
      if (rcnt >= rdly[got_n]) begin
        got[got_n] = rx_data; got_n++; rx_ready = 1'b1; rcnt = 0;
      end else rcnt++;
    end
  end

  always @(posedge clk) hs <= tx_valid && tx_ready;

  always @(negedge clk) begin
    if (!tx_armed) tx_valid = 1'b0;
    else if (hs) begin tx_valid = 1'b0; tx_idx++; tcnt = 0; end
    else if (!tx_valid && tx_idx < tx_total) begin
      if (tcnt >= tdly[tx_idx]) begin tx_valid = 1'b1; tx_data = tbytes[tx_idx]; end
      else tcnt++;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (scl_line && prev_scl && dut_sda_low != prev_sda_drv) sda_viol++;
      if (dut_scl_low && !prev_scl_drv && prev_scl) scl_viol++;
    end
    prev_scl = scl_line; prev_sda_drv = dut_sda_low; prev_scl_drv = dut_scl_low;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_high(output int w);
    wcyc(1);
    w = 0;
    while (!scl_line) begin wcyc(1); w++; end
  endtask

  task automatic m_start();
    int w;
    m_sda_low = 1'b0; wcyc(Q);
    m_scl_low = 1'b0; wait_high(w); wcyc(H);
    m_sda_low = 1'b1; wcyc(H);
    m_scl_low = 1'b1; wcyc(Q);
  endtask

  task automatic m_stop();
    int w;
    m_sda_low = 1'b1; wcyc(Q);
    m_scl_low = 1'b0; wait_high(w); wcyc(H);
    m_sda_low = 1'b0; wcyc(H);
  endtask

  task automatic m_wbit(input logic b);
    int w;
    m_sda_low = ~b; wcyc(Q);
    m_scl_low = 1'b0; wait_high(w); wcyc(H);
    m_scl_low = 1'b1; wcyc(Q);
  endtask

  task automatic m_rbit(output logic b, output int w);
    m_sda_low = 1'b0; wcyc(Q);
    m_scl_low = 1'b0; wait_high(w); wcyc(H/2);
    b = sda_line; wcyc(H/2);
    m_scl_low = 1'b1; wcyc(Q);
  endtask

  task automatic m_wbyte(input logic [7:0] v, output logic ack, output int w);
    for (int i = 7; i >= 0; i--) m_wbit(v[i]);
    m_rbit(ack, w);
  endtask

  task automatic m_rbyte(input logic give_ack, output logic [7:0] v, output int w0);
    logic b; int w;
    v = '0; w0 = 0;
    for (int i = 0; i < 8; i++) begin
      m_rbit(b, w);
      if (i == 0) w0 = w;
      v = {v[6:0], b};
    end
    m_wbit(~give_ack);
  endtask

  function automatic bit addr_hit(input logic [6:0] a);
    return a == TGT;
  endfunction

  task automatic do_write(input logic [6:0] a, input int n);
    logic ack; int w; bit hit;
    hit = addr_hit(a);
    got_n = 0;
    m_start();
    m_wbyte({a, 1'b0}, ack, w);
    if (hit) chk(ack == 1'b0, "R1 addr ack", ack, 0);
    else chk(ack == 1'b1, "R2 no ack on mismatch", ack, 1);
    for (int i = 0; i < n; i++) begin
      m_wbyte(wb[i], ack, w);
      if (hit) begin
        chk(ack == 1'b0, "R4 data ack", ack, 0);
        if (rdly[i] >= RX_SLOW) chk(w > 0, "R5 stretch when rx slow", w, 1);
        else chk(w == 0, "R5 no stretch when rx fast", w, 0);
      end else chk(ack == 1'b1 && w == 0, "R2 ignored data", ack, 1);
    end
    m_stop();
    wcyc(200);
    if (hit) begin
      chk(got_n == n, "R3 byte count", got_n, n);
      for (int i = 0; i < n && i < got_n; i++)
        chk(got[i] == wb[i], "R3 byte value", got[i], wb[i]);
    end else chk(got_n == 0, "R2 nothing received", got_n, 0);
  endtask

  task automatic do_read(input logic [6:0] a, input int n);
    logic ack; int w; bit hit; logic [7:0] v;
    hit = addr_hit(a);
    tx_armed = 1'b0; wcyc(2);
    tx_idx = 0; tcnt = 0; tx_total = n + 1; tx_armed = 1'b1;
    m_start();
    m_wbyte({a, 1'b1}, ack, w);
    if (hit) begin
      chk(ack == 1'b0, "R1 addr ack read", ack, 0);
      for (int i = 0; i < n; i++) begin
        m_rbyte(i < n - 1, v, w);
        chk(v == tbytes[i], "R6 read byte", v, tbytes[i]);
        if (tdly[i] >= TX_SLOW) chk(w > 0, "R7 stretch when tx slow", w, 1);
        else chk(w == 0, "R7 no stretch when tx ready", w, 0);
      end
      wcyc(2);
      chk(dut_sda_low == 1'b0, "R8 SDA released after NACK", dut_sda_low, 0);
    end else chk(ack == 1'b1, "R2 no ack on read mismatch", ack, 1);
    m_stop();
    wcyc(100);
    chk(tx_idx == (hit ? n : 0), "R8 bytes taken", tx_idx, hit ? n : 0);
    tx_armed = 1'b0; wcyc(5);
  endtask

  initial begin
    logic ack; int w; int n; logic [6:0] a;
    void'($urandom(32'd917));
    for (int i = 0; i < 16; i++) begin rdly[i] = 0; tdly[i] = 0; end
    wcyc(5);
    chk(dut_scl_low == 0 && dut_sda_low == 0, "R11 lines released in reset",
        {dut_scl_low, dut_sda_low}, 0);
    rst_n = 1'b1; wcyc(5);
    chk(rx_valid == 0 && tx_ready == 0, "R11 idle handshakes", {rx_valid, tx_ready}, 0);

    wb[0] = 8'hA5; wb[1] = 8'h01; wb[2] = 8'h80;
    do_write(TGT, 3);

    wb[0] = 8'h3C; wb[1] = 8'hFF; rdly[0] = RX_SLOW + 20; rdly[1] = 2;
    do_write(TGT, 2);
    rdly[0] = 0; rdly[1] = 0;

    wb[0] = 8'h77;
    do_write(TGT ^ 7'h01, 1);

    tbytes[0] = 8'hC3; tbytes[1] = 8'h5A; tbytes[2] = 8'h81; tbytes[3] = 8'hEE;
    do_read(TGT, 3);

    tdly[0] = TX_SLOW; tdly[1] = 1; tdly[2] = TX_SLOW;
    do_read(TGT, 3);
    for (int i = 0; i < 16; i++) tdly[i] = 0;

    do_read(TGT ^ 7'h40, 2);

    got_n = 0;
    m_start();
    m_wbyte({TGT, 1'b0}, ack, w);
    m_wbit(1'b1); m_wbit(1'b0); m_wbit(1'b1); m_wbit(1'b1);
    m_start();
    m_wbyte({TGT, 1'b0}, ack, w);
    chk(ack == 1'b0, "R9 addr ack after restart", ack, 0);
    m_wbyte(8'h5A, ack, w);
    chk(ack == 1'b0, "R9 data ack after restart", ack, 0);
    m_stop(); wcyc(100);
    chk(got_n == 1 && got[0] == 8'h5A, "R9 byte after restart", got[0], 8'h5A);

    for (int t = 0; t < 12; t++) begin
      a = ($urandom_range(0, 1) == 1) ? TGT : TGT ^ 7'($urandom_range(1, 127));
      n = $urandom_range(1, 3);
      for (int i = 0; i < n; i++) begin
        wb[i] = 8'($urandom); tbytes[i] = 8'($urandom);
        rdly[i] = ($urandom_range(0, 3) == 0) ? RX_SLOW + 10 : $urandom_range(0, 3);
        tdly[i] = ($urandom_range(0, 3) == 0) ? TX_SLOW : $urandom_range(0, 3);
      end
      tbytes[n] = 8'($urandom); tdly[n] = 0;
      if ($urandom_range(0, 1) == 1) do_write(a, n);
      else do_read(a, n);
    end

    chk(sda_viol == 0, "R6 SDA steady while SCL high", sda_viol, 0);
    chk(scl_viol == 0, "R10 SCL pulled only in low phase", scl_viol, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule